// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where instruction fetch goes next in a 32-bit load-store pipeline whose instructions are all one 32-bit word wide and word aligned. Each enabled cycle it takes the address of the current instruction, the instruction word, two register operands for comparison and one register value for indirect jumps. From these it registers the following address, a flag telling whether control flow left the straight-line path, a return address with a valid flag for the linking forms, and a flag for an unaligned indirect target.

It handles six kinds of control flow. Plain instructions fall through. Two branches compare registers for equality or inequality. Four branches test the sign of one register against zero. Direct jumps replace the low address bits and keep the current 256 MB region. Indirect jumps read their destination from a register. One direct jump and one indirect jump also hand back a return address. Branch displacements count in words, are signed and are measured from the fall-through address.

The block sits after decode. The fetch stage consumes its registered outputs one cycle after the inputs were presented with the enable high.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and until the synchronised reset has released, `npc_o` equals the parameter `RESET_PC` (default 0) and `taken_o`, `link_vld_o`, `misalign_o` and `link_addr_o` are all zero.
- R2: Outputs update only on a rising clock edge with `dec_en` high. With `dec_en` low, every output keeps its value whatever the other inputs do.
- R3: Any instruction word that is not one of the control forms in R4 to R7 yields `npc_o` = PC + 4 and `taken_o` = 0. This includes opcode 1 with a selector in bits [20:16] other than 0 or 1, and opcode 0 with a function code in bits [5:0] other than 8 or 9. The opcode is bits [31:26].
- R4: Opcode 4 is taken when `rs_val_i` equals `rt_val_i`, and opcode 5 is taken when they differ. A taken branch goes to PC + 4 + (sign-extended bits [15:0] shifted left by 2). A branch that is not taken goes to PC + 4.
- R5: Sign tests on `rs_val_i` as a signed value use the same target rule as R4. Opcode 6 is taken when the value is <= 0 and opcode 7 when it is > 0. Opcode 1 with selector 0 is taken when the value is < 0, and opcode 1 with selector 1 when it is >= 0.
- R6: Opcodes 2 and 3 always go to {(PC+4)[31:28], bits [25:0], 2'b00}, so the region is taken from the fall-through address.
- R7: Opcode 0 with function 8 or 9 goes to `jreg_val_i` with its two low bits cleared. `misalign_o` is 1 exactly when those two bits of `jreg_val_i` were non-zero.
- R8: `link_vld_o` is 1 only for opcode 3 and for opcode 0 with function 9. `link_addr_o` always carries PC + 4 of the instruction just registered.
- R9: `taken_o` is 1 for every jump and every taken branch and 0 otherwise, and `npc_o` is word aligned whenever the PC was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_en | input | 1 | Clock enable for the output registers |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | First comparison operand, also the operand of the sign tests |
| rt_val_i | input | 32 | Second comparison operand |
| jreg_val_i | input | 32 | Destination for indirect jumps |
| npc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Control flow left the sequential path |
| link_vld_o | output | 1 | Instruction was a linking jump |
| link_addr_o | output | 32 | Return address (PC + 4) |
| misalign_o | output | 1 | Indirect destination had non-zero low bits |

## Verification
Random instruction words are drawn across every opcode and selector, including undefined selector and function codes, so that control forms can be told apart from fall-through words. Operands are biased toward equal pairs and toward zero, negative and positive values, which separates taken from not-taken and, in the sign tests, places the strict and non-strict comparisons either side of zero. Directed cases cover the most negative and most positive displacements, a backward branch that wraps below address zero, a direct jump from the last word of a 256 MB region (which must land in the next region), unaligned indirect destinations, and the enable held low while inputs change.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int SEL_W   = 5;
  localparam int FN_W    = 6;

  localparam logic [OP_W-1:0]  OP_REG    = 6'd0;
  localparam logic [OP_W-1:0]  OP_SIGN   = 6'd1;
  localparam logic [OP_W-1:0]  OP_JMP    = 6'd2;
  localparam logic [OP_W-1:0]  OP_JMPL   = 6'd3;
  localparam logic [OP_W-1:0]  OP_BREQ   = 6'd4;
  localparam logic [OP_W-1:0]  OP_BRNE   = 6'd5;
  localparam logic [OP_W-1:0]  OP_BRLEZ  = 6'd6;
  localparam logic [OP_W-1:0]  OP_BRGTZ  = 6'd7;
  localparam logic [SEL_W-1:0] SEL_LTZ   = 5'd0;
  localparam logic [SEL_W-1:0] SEL_GEZ   = 5'd1;
  localparam logic [FN_W-1:0]  FN_JREG   = 6'd8;
  localparam logic [FN_W-1:0]  FN_JREGL  = 6'd9;

  typedef enum logic [3:0] {
    CF_SEQ, CF_EQ, CF_NE, CF_LEZ, CF_GTZ, CF_LTZ, CF_GEZ, CF_JABS, CF_JREG
  } cf_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [FN_W-1:0]  fn_i,
  output cf_kind_e         kind_o,
  output logic             link_o
);
  always_comb begin
    kind_o = CF_SEQ;
    link_o = 1'b0;
    case (op_i)
      OP_BREQ:  kind_o = CF_EQ;
      OP_BRNE:  kind_o = CF_NE;
      OP_BRLEZ: kind_o = CF_LEZ;
      OP_BRGTZ: kind_o = CF_GTZ;
      OP_SIGN: begin
        if (sel_i == SEL_LTZ)      kind_o = CF_LTZ;
        else if (sel_i == SEL_GEZ) kind_o = CF_GEZ;
      end
      OP_JMP:   kind_o = CF_JABS;
      OP_JMPL: begin
        kind_o = CF_JABS;
        link_o = 1'b1;
      end
      OP_REG: begin
        if (fn_i == FN_JREG) kind_o = CF_JREG;
        else if (fn_i == FN_JREGL) begin
          kind_o = CF_JREG;
          link_o = 1'b1;
        end
      end
      default: kind_o = CF_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cf_kind_e           kind_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic               take_o
);
  logic same, neg, zero;

  always_comb begin
    same = (a_i == b_i);
    neg  = a_i[DATA_W-1];
    zero = (a_i == '0);
    case (kind_i)
      CF_EQ:   take_o = same;
      CF_NE:   take_o = !same;
      CF_LEZ:  take_o = neg || zero;
      CF_GTZ:  take_o = !neg && !zero;
      CF_LTZ:  take_o = neg;
      CF_GEZ:  take_o = !neg;
      CF_JABS: take_o = 1'b1;
      CF_JREG: take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [ADDR_W-1:0] jreg_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jabs_o,
  output logic [ADDR_W-1:0] jreg_o,
  output logic              jmis_o
);
  localparam int ALIGN_W  = 2;
  localparam int EXT_W    = ADDR_W - OFF_W - ALIGN_W;
  localparam int REGION_W = ADDR_W - JIDX_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(1 << ALIGN_W);

  logic [ADDR_W-1:0] disp;

  always_comb begin
    seq_o  = pc_i + WORD_BYTES;
    disp   = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN_W{1'b0}}};
    br_o   = seq_o + disp;
    jabs_o = {seq_o[ADDR_W-1 -: REGION_W], jidx_i, {ALIGN_W{1'b0}}};
    jreg_o = {jreg_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    jmis_o = |jreg_i[ALIGN_W-1:0];
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [31:0]     RESET_PC = 32'h0000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_en,
  input  logic [ADDR_W-1:0]       pc_i,
  input  logic [INSTR_W-1:0]      instr_i,
  input  logic [DATA_W-1:0]       rs_val_i,
  input  logic [DATA_W-1:0]       rt_val_i,
  input  logic [ADDR_W-1:0]       jreg_val_i,
  output logic [ADDR_W-1:0]       npc_o,
  output logic                    taken_o,
  output logic                    link_vld_o,
  output logic [ADDR_W-1:0]       link_addr_o,
  output logic                    misalign_o
);
  localparam int OFF_W  = 16;
  localparam int JIDX_W = 26;
  localparam int SEL_LO = OFF_W;
  localparam int FN_LO  = 0;
  localparam int OP_LO  = INSTR_W - OP_W;
  localparam int SYNC_N = 2;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_q = rst_sync[SYNC_N-1];

  cf_kind_e          kind;
  logic              is_link, take;
  logic [ADDR_W-1:0] seq, br_tgt, jabs_tgt, jreg_tgt;
  logic              jmis;

  npc_decode u_dec (
    .op_i   (instr_i[OP_LO +: OP_W]),
    .sel_i  (instr_i[SEL_LO +: SEL_W]),
    .fn_i   (instr_i[FN_LO +: FN_W]),
    .kind_o (kind),
    .link_o (is_link)
  );

  npc_cond #(.DATA_W(DATA_W)) u_cond (
    .kind_i (kind),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .take_o (take)
  );

  npc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i   (pc_i),
    .off_i  (instr_i[OFF_W-1:0]),
    .jidx_i (instr_i[JIDX_W-1:0]),
    .jreg_i (jreg_val_i),
    .seq_o  (seq),
    .br_o   (br_tgt),
    .jabs_o (jabs_tgt),
    .jreg_o (jreg_tgt),
    .jmis_o (jmis)
  );

  // next-state
  logic [ADDR_W-1:0] npc_d;
  logic              mis_d;

  always_comb begin
    npc_d = seq;
    mis_d = 1'b0;
    if (take) begin
      case (kind)
        CF_JABS: npc_d = jabs_tgt;
        CF_JREG: begin
          npc_d = jreg_tgt;
          mis_d = jmis;
        end
        default: npc_d = br_tgt;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      npc_o       <= ADDR_W'(RESET_PC);
      taken_o     <= 1'b0;
      link_vld_o  <= 1'b0;
      link_addr_o <= '0;
      misalign_o  <= 1'b0;
    end else if (dec_en) begin
      npc_o       <= npc_d;
      taken_o     <= take;
      link_vld_o  <= is_link;
      link_addr_o <= seq;
      misalign_o  <= mis_d;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !dec_en |=> ($stable(npc_o) && $stable(taken_o) && $stable(link_addr_o)));

  // R3
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dec_en |=> (taken_o || npc_o == $past(pc_i) + ADDR_W'(4)));

  // R6
  region_kept_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_en && instr_i[OP_LO +: OP_W] == OP_JMP)
      |=> (taken_o && npc_o[ADDR_W-1 -: 4] == $past(pc_i + ADDR_W'(4)) >> (ADDR_W-4)));

  // R7
  misalign_only_jump_chk: assert property (@(posedge clk) disable iff (!rst_q)
    misalign_o |-> (taken_o && npc_o[1:0] == 2'b00));

  // R8
  link_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dec_en |=> (link_addr_o == $past(pc_i) + ADDR_W'(4)));

  // R8
  link_only_jump_chk: assert property (@(posedge clk) disable iff (!rst_q)
    link_vld_o |-> taken_o);

  // R9
  aligned_next_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dec_en && pc_i[1:0] == 2'b00) |=> (npc_o[1:0] == 2'b00));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_en;
  logic [31:0] pc_i, instr_i, rs_val_i, rt_val_i, jreg_val_i;
  logic [31:0] npc_o, link_addr_o;
  logic        taken_o, link_vld_o, misalign_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .jreg_val_i(jreg_val_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_vld_o(link_vld_o),
    .link_addr_o(link_addr_o), .misalign_o(misalign_o)
  );

  // expected: {npc, taken, link_vld, link_addr, misalign}
  function automatic logic [66:0] model(input logic [31:0] pc, ins, a, b, j);
    logic [5:0]  op  = ins[31:26];
    logic [4:0]  sel = ins[20:16];
    logic [5:0]  fn  = ins[5:0];
    logic [31:0] s4  = pc + 32'd4;
    logic [31:0] bt  = s4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    logic [31:0] n   = s4;
    logic        t   = 1'b0, l = 1'b0, m = 1'b0;
    case (op)
      6'd4: t = (a == b);
      6'd5: t = (a != b);
      6'd6: t = ($signed(a) <= 0);
      6'd7: t = ($signed(a) > 0);
      6'd1: if (sel == 5'd0) t = ($signed(a) < 0);
            else if (sel == 5'd1) t = ($signed(a) >= 0);
      default: ;
    endcase
    if (t) n = bt;
    if (op == 6'd2 || op == 6'd3) begin
      t = 1'b1; n = {s4[31:28], ins[25:0], 2'b00}; l = (op == 6'd3);
    end
    if (op == 6'd0 && (fn == 6'd8 || fn == 6'd9)) begin
      t = 1'b1; n = {j[31:2], 2'b00}; m = |j[1:0]; l = (fn == 6'd9);
    end
    return {n, t, l, s4, m};
  endfunction

  function automatic string tag(input logic [31:0] ins);
    case (ins[31:26])
      6'd4, 6'd5:       return "R4";
      6'd6, 6'd7:       return "R5";
      6'd1:             return (ins[20:16] < 5'd2) ? "R5" : "R3";
      6'd2, 6'd3:       return "R6";
      6'd0:             return (ins[5:0] == 6'd8 || ins[5:0] == 6'd9) ? "R7" : "R3";
      default:          return "R3";
    endcase
  endfunction

  task automatic compare(input string req, input logic [66:0] exp);
    logic [66:0] act = {npc_o, taken_o, link_vld_o, link_addr_o, misalign_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act npc=%h t=%b l=%b la=%h m=%b exp npc=%h t=%b l=%b la=%h m=%b",
               req, act[66:35], act[34], act[33], act[32:1], act[0],
               exp[66:35], exp[34], exp[33], exp[32:1], exp[0]);
    end
  endtask

  // present one instruction, check after the registering edge
  task automatic run(input logic [31:0] pc, ins, a, b, j, input string req = "");
    logic [66:0] exp = model(pc, ins, a, b, j);
    @(negedge clk);
    dec_en = 1'b1; pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b; jreg_val_i = j;
    @(negedge clk);
    dec_en = 1'b0;
    compare((req == "") ? tag(ins) : req, exp);
    if (exp[34] && !taken_o) ; // covered by compare
  endtask

  function automatic logic [31:0] pick_val(input int k);
    case (k % 4)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000 | $urandom;
      default: return 32'h0000_0001 + ($urandom & 32'h3FFF_FFFF);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [66:0] held;
    void'($urandom(32'd2005));
    rst_n = 1'b0; dec_en = 1'b0;
    pc_i = '0; instr_i = '0; rs_val_i = '0; rt_val_i = '0; jreg_val_i = '0;
    repeat (3) @(negedge clk);
    compare("R1", {32'h0, 1'b0, 1'b0, 32'h0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", {32'h0, 1'b0, 1'b0, 32'h0, 1'b0});
    repeat (3) @(negedge clk);

    // R4 equal / not equal, both outcomes, extreme offsets
    run(32'h0000_1000, {6'd4, 5'd1, 5'd2, 16'h7FFF}, 32'd5, 32'd5, 0, "R4");
    run(32'h0000_1000, {6'd4, 5'd1, 5'd2, 16'h7FFF}, 32'd5, 32'd6, 0, "R4");
    run(32'h0000_1000, {6'd5, 5'd1, 5'd2, 16'h8000}, 32'd5, 32'd6, 0, "R4");
    run(32'h0000_1000, {6'd5, 5'd1, 5'd2, 16'h8000}, 32'd7, 32'd7, 0, "R4");
    run(32'h0000_0000, {6'd4, 5'd1, 5'd2, 16'hFFFD}, 32'd0, 32'd0, 0, "R4");
    // R5 sign tests at and around zero
    run(32'h0000_2000, {6'd6, 5'd3, 5'd0, 16'hFFFF}, 32'd0, 0, 0, "R5");
    run(32'h0000_2000, {6'd6, 5'd3, 5'd0, 16'hFFFF}, 32'd1, 0, 0, "R5");
    run(32'h0000_2000, {6'd7, 5'd3, 5'd0, 16'h0010}, 32'd0, 0, 0, "R5");
    run(32'h0000_2000, {6'd7, 5'd3, 5'd0, 16'h0010}, 32'd1, 0, 0, "R5");
    run(32'h0000_2000, {6'd1, 5'd3, 5'd0, 16'h0010}, 32'hFFFF_FFFF, 0, 0, "R5");
    run(32'h0000_2000, {6'd1, 5'd3, 5'd0, 16'h0010}, 32'd0, 0, 0, "R5");
    run(32'h0000_2000, {6'd1, 5'd3, 5'd1, 16'h0010}, 32'd0, 0, 0, "R5");
    run(32'h0000_2000, {6'd1, 5'd3, 5'd1, 16'h0010}, 32'h8000_0000, 0, 0, "R5");
    run(32'h0000_2000, {6'd1, 5'd3, 5'd2, 16'h0010}, 32'h8000_0000, 0, 0, "R3");
    // R6 region boundary: last word of region 0 jumps into region 1
    run(32'h0FFF_FFFC, {6'd2, 26'h000_0040}, 0, 0, 0, "R6");
    run(32'h7000_0010, {6'd3, 26'h3FF_FFFF}, 0, 0, 0, "R6");
    // R7 register jumps, aligned and not
    run(32'h0000_3000, {6'd0, 20'h0, 6'd8}, 0, 0, 32'h1234_5678, "R7");
    run(32'h0000_3000, {6'd0, 20'h0, 6'd9}, 0, 0, 32'h1234_567B, "R7");
    run(32'h0000_3000, {6'd0, 20'h0, 6'd10}, 0, 0, 32'h1234_567B, "R3");
    // R8 link only on linking forms
    run(32'h0000_4000, {6'd3, 26'h0}, 0, 0, 0, "R8");
    run(32'h0000_4000, {6'd0, 20'h0, 6'd9}, 0, 0, 32'h40, "R8");
    // R3 plain word
    run(32'h0000_5000, {6'd35, 26'h123_4567}, 0, 0, 0, "R3");

    // R2 enable low: outputs held
    held = {npc_o, taken_o, link_vld_o, link_addr_o, misalign_o};
    @(negedge clk);
    pc_i = 32'hABCD_0000; instr_i = {6'd2, 26'h1}; jreg_val_i = 32'h3;
    @(negedge clk);
    @(negedge clk);
    compare("R2", held);

    // random mix, R9 via taken flag in every compare
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  op;
      logic [31:0] ins, a, b, pc;
      int k = $urandom_range(0, 9);
      op  = (k < 8) ? 6'(k) : 6'($urandom_range(8, 63));
      ins = {op, 26'($urandom)};
      if (op == 6'd1 && $urandom_range(0, 2) != 0) ins[20:16] = 5'($urandom_range(0, 1));
      if (op == 6'd0 && $urandom_range(0, 2) != 0) ins[5:0] = 6'($urandom_range(8, 9));
      pc = {$urandom, 2'b00} >> 0;
      pc[1:0] = 2'b00;
      a = pick_val($urandom_range(0, 3));
      b = ($urandom_range(0, 1) == 1) ? a : pick_val($urandom_range(0, 3));
      run(pc, ins, a, b, $urandom, (i % 2 == 0) ? "R9" : "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule